// File: doc/BRIEF.md
# Effective Address Qualifier and Fault Reporter

This block sits on both ends of a radix address translation path. On the way in, it takes an effective address, the access kind and the two relocation-enable bits. It decides whether the access bypasses translation or must be walked. For an access that is walked, it picks the process identifier from the two top address bits. On the way out, it takes the storage faults raised by the table-walk and permission blocks. Together with the segment faults it detects itself, it turns each one into an exception class and loads the fault-address and fault-status registers.

Every qualified request shows up on the registered outputs one clock after it is presented. A bypass request carries its real address and full permissions. A translated request carries its process and partition identifiers. Each exception appears as a one-cycle pulse, and the register writes it causes take effect on the same clock edge.

Top module: `eaqf_top`

## Requirements
- R1: While reset is held and on the first cycle after it, `q_valid` and `exc_valid` are 0, and `far`, `fsr` and `err_code` are 0.
- R2: A request is in bypass when its kind is fetch (`acc`=2) with `ir_en`=0, or its kind is read (0) or write (1) with `dr_en`=0. The relocation bit of the other kind has no effect. One cycle later the outputs show `q_valid`=1, `q_real`=1, `q_addr` equal to the address with bits [63:60] cleared, and `q_perm`=3'b111. No exception is raised, whatever the quadrant.
- R3: A translated request with address bits [63:62]=0 gives, one cycle later, `q_valid`=1, `q_real`=0, `q_addr` equal to the address, `q_pid`=`pid_reg`, `q_lpid`=`lpid_reg` and `q_perm`=0.
- R4: A translated request with bits [63:62]=3 gives `q_pid`=0 and `q_lpid`=`lpid_reg`, with the other outputs as in R3.
- R5: A translated fetch with bits [63:62] equal to 1 or 2 gives `q_valid`=0 and one cycle later an exception with `exc_code`=1 (instruction segment) and `err_code`=0. `far` and `fsr` are unchanged.
- R6: A translated read or write with bits [63:62] equal to 1 or 2 gives `exc_code`=2 (data segment), `err_code`=0 and `far` loaded with the address. `fsr` is unchanged.
- R7: A storage fault reported for a fetch gives `exc_code`=3 and `err_code` equal to the fault cause. `far` and `fsr` are unchanged.
- R8: A storage fault reported for a read gives `exc_code`=4, `err_code`=0, `fsr` equal to the cause and `far` equal to the fault address.
- R9: A storage fault reported for a write loads `fsr` with the cause ORed with the store flag at bit 25; the rest is as in R8.
- R10: `exc_valid` is high for exactly one cycle per fault. Between faults it is 0 and `far` and `fsr` hold their values.
- R11: When a storage fault and a segment fault arrive in the same cycle, only the storage fault is reported and the segment fault is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_ea | input | 64 | Effective address of request |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| ir_en | input | 1 | Instruction relocation enable |
| dr_en | input | 1 | Data relocation enable |
| pid_reg | input | 20 | Current process identifier register |
| lpid_reg | input | 12 | Partition identifier register |
| flt_valid | input | 1 | Storage fault from walk/permission blocks |
| flt_ea | input | 64 | Address of the faulting access |
| flt_acc | input | 2 | Access kind of the faulting access |
| flt_cause | input | 32 | Fault cause bits |
| q_valid | output | 1 | Qualified request valid |
| q_real | output | 1 | Request bypasses translation |
| q_addr | output | 64 | Real address (bypass) or effective address |
| q_perm | output | 3 | Granted permissions {exec, write, read} |
| q_pid | output | 20 | Selected process identifier |
| q_lpid | output | 12 | Selected partition identifier |
| exc_valid | output | 1 | Exception pulse |
| exc_code | output | 3 | 1 inst segment, 2 data segment, 3 inst storage, 4 data storage |
| err_code | output | 32 | Error code carried with the exception |
| far | output | 64 | Fault-address register |
| fsr | output | 32 | Fault-status register |

## Verification
The qualifier is driven with each of the four quadrants under every pairing of access kind and relocation bits. This separates a bypass decided by the wrong relocation bit from a correct one, and a bypass from an illegal quadrant that must be ignored. The fault side is driven with fetch, read and write faults of different causes and addresses. This shows which register each class touches and which it must leave alone, and whether the store flag is added. Back-to-back and simultaneous faults check the single-cycle pulse and the priority of storage faults over segment faults.

// File: rtl/eaqf_pkg.sv
package eaqf_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_BAD   = 2'd3
    } acc_e;

    typedef enum logic [2:0] {
        EXC_NONE = 3'd0,
        EXC_ISEG = 3'd1,
        EXC_DSEG = 3'd2,
        EXC_ISTO = 3'd3,
        EXC_DSTO = 3'd4
    } exc_e;

    typedef enum logic [1:0] {
        QD_APP  = 2'd0,
        QD_BAD1 = 2'd1,
        QD_BAD2 = 2'd2,
        QD_OS   = 2'd3
    } quad_e;

    function automatic logic quad_legal(input quad_e q);
        return (q == QD_APP) || (q == QD_OS);
    endfunction

    function automatic logic is_fetch(input logic [1:0] a);
        return acc_e'(a) == ACC_FETCH;
    endfunction

endpackage

// File: rtl/eaqf_mode_decode.sv
module eaqf_mode_decode
    import eaqf_pkg::*;
#(
    parameter int EA_W  = 64,
    parameter int PID_W = 20,
    parameter int TOP_CLR = 4
) (
    input  logic [EA_W-1:0]  ea,
    input  logic [1:0]       acc,
    input  logic             ir_en,
    input  logic             dr_en,
    input  logic [PID_W-1:0] pid_reg,
    output logic             bypass,
    output logic             seg_bad,
    output logic [EA_W-1:0]  addr_out,
    output logic [PID_W-1:0] pid_sel
);
    localparam logic [EA_W-1:0] KEEP_MASK = {{TOP_CLR{1'b0}}, {(EA_W-TOP_CLR){1'b1}}};

    quad_e quad;

    always_comb begin
        quad     = quad_e'(ea[EA_W-1 -: 2]);
        bypass   = is_fetch(acc) ? !ir_en : !dr_en;
        seg_bad  = !bypass && !quad_legal(quad);
        addr_out = bypass ? (ea & KEEP_MASK) : ea;
        pid_sel  = (quad == QD_OS) ? '0 : pid_reg;
    end
endmodule

// File: rtl/eaqf_fault_report.sv
module eaqf_fault_report
    import eaqf_pkg::*;
#(
    parameter int EA_W      = 64,
    parameter int CAUSE_W   = 32,
    parameter int STORE_BIT = 25
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               seg_req,
    input  logic [1:0]         seg_acc,
    input  logic [EA_W-1:0]    seg_ea,
    input  logic               flt_valid,
    input  logic [1:0]         flt_acc,
    input  logic [EA_W-1:0]    flt_ea,
    input  logic [CAUSE_W-1:0] flt_cause,
    output logic               exc_valid,
    output exc_e               exc_code,
    output logic [CAUSE_W-1:0] err_code,
    output logic [EA_W-1:0]    far,
    output logic [CAUSE_W-1:0] fsr
);
    localparam logic [CAUSE_W-1:0] STORE_FLAG = CAUSE_W'(1) << STORE_BIT;

    always_ff @(posedge clk) begin
        if (rst) begin
            exc_valid <= 1'b0;
            exc_code  <= EXC_NONE;
            err_code  <= '0;
            far       <= '0;
            fsr       <= '0;
        end else if (flt_valid) begin
            exc_valid <= 1'b1;
            if (is_fetch(flt_acc)) begin
                exc_code <= EXC_ISTO;
                err_code <= flt_cause;
            end else begin
                exc_code <= EXC_DSTO;
                err_code <= '0;
                far      <= flt_ea;
                fsr      <= (acc_e'(flt_acc) == ACC_WRITE) ? (flt_cause | STORE_FLAG) : flt_cause;
            end
        end else if (seg_req) begin
            exc_valid <= 1'b1;
            err_code  <= '0;
            if (is_fetch(seg_acc)) begin
                exc_code <= EXC_ISEG;
            end else begin
                exc_code <= EXC_DSEG;
                far      <= seg_ea;
            end
        end else begin
            exc_valid <= 1'b0;
            exc_code  <= EXC_NONE;
        end
    end

    p_isto_keeps_far_r7: assert property (@(posedge clk) disable iff (rst)
        exc_valid && exc_code == EXC_ISTO |-> $stable(far) && $stable(fsr));
    p_iseg_keeps_far_r5: assert property (@(posedge clk) disable iff (rst)
        exc_valid && exc_code == EXC_ISEG |-> $stable(far) && err_code == '0);
    p_store_flag_r9: assert property (@(posedge clk) disable iff (rst)
        flt_valid && acc_e'(flt_acc) == ACC_WRITE |=> fsr[STORE_BIT]);
    p_storage_wins_r11: assert property (@(posedge clk) disable iff (rst)
        flt_valid && seg_req |=> exc_code inside {EXC_ISTO, EXC_DSTO});
    p_idle_holds_r10: assert property (@(posedge clk) disable iff (rst)
        !flt_valid && !seg_req |=> !exc_valid && $stable(far) && $stable(fsr));
endmodule

// File: rtl/eaqf_top.sv
module eaqf_top
    import eaqf_pkg::*;
#(
    parameter int EA_W      = 64,
    parameter int PID_W     = 20,
    parameter int LPID_W    = 12,
    parameter int CAUSE_W   = 32,
    parameter int STORE_BIT = 25
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [EA_W-1:0]    req_ea,
    input  logic [1:0]         req_acc,
    input  logic               ir_en,
    input  logic               dr_en,
    input  logic [PID_W-1:0]   pid_reg,
    input  logic [LPID_W-1:0]  lpid_reg,
    input  logic               flt_valid,
    input  logic [EA_W-1:0]    flt_ea,
    input  logic [1:0]         flt_acc,
    input  logic [CAUSE_W-1:0] flt_cause,
    output logic               q_valid,
    output logic               q_real,
    output logic [EA_W-1:0]    q_addr,
    output logic [2:0]         q_perm,
    output logic [PID_W-1:0]   q_pid,
    output logic [LPID_W-1:0]  q_lpid,
    output logic               exc_valid,
    output logic [2:0]         exc_code,
    output logic [CAUSE_W-1:0] err_code,
    output logic [EA_W-1:0]    far,
    output logic [CAUSE_W-1:0] fsr
);
    logic             bypass, seg_bad;
    logic [EA_W-1:0]  addr_d;
    logic [PID_W-1:0] pid_d;
    exc_e             exc_code_e;

    eaqf_mode_decode #(.EA_W(EA_W), .PID_W(PID_W), .TOP_CLR(4)) dec_i (
        .ea(req_ea), .acc(req_acc), .ir_en(ir_en), .dr_en(dr_en),
        .pid_reg(pid_reg), .bypass(bypass), .seg_bad(seg_bad),
        .addr_out(addr_d), .pid_sel(pid_d)
    );

    eaqf_fault_report #(.EA_W(EA_W), .CAUSE_W(CAUSE_W), .STORE_BIT(STORE_BIT)) flt_i (
        .clk(clk), .rst(rst),
        .seg_req(req_valid && seg_bad), .seg_acc(req_acc), .seg_ea(req_ea),
        .flt_valid(flt_valid), .flt_acc(flt_acc), .flt_ea(flt_ea), .flt_cause(flt_cause),
        .exc_valid(exc_valid), .exc_code(exc_code_e), .err_code(err_code),
        .far(far), .fsr(fsr)
    );

    assign exc_code = exc_code_e;

    always_ff @(posedge clk) begin
        if (rst) begin
            q_valid <= 1'b0;
            q_real  <= 1'b0;
            q_addr  <= '0;
            q_perm  <= '0;
            q_pid   <= '0;
            q_lpid  <= '0;
        end else begin
            q_valid <= req_valid && !seg_bad;
            q_real  <= bypass;
            q_addr  <= addr_d;
            q_perm  <= bypass ? 3'b111 : 3'b000;
            q_pid   <= bypass ? '0 : pid_d;
            q_lpid  <= bypass ? '0 : lpid_reg;
        end
    end

    p_acc_legal_r2: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> req_acc != 2'd3);
    p_real_top_clear_r2: assert property (@(posedge clk) disable iff (rst)
        q_valid && q_real |-> q_addr[EA_W-1 -: 4] == 4'd0 && q_perm == 3'b111);
    p_app_pid_r3: assert property (@(posedge clk) disable iff (rst)
        req_valid && !bypass && req_ea[EA_W-1 -: 2] == 2'd0 |=> q_pid == $past(pid_reg));
    p_os_pid_r4: assert property (@(posedge clk) disable iff (rst)
        q_valid && !q_real && q_addr[EA_W-1 -: 2] == 2'd3 |-> q_pid == '0);
    p_no_valid_illegal_r5: assert property (@(posedge clk) disable iff (rst)
        q_valid && !q_real |-> q_addr[EA_W-1 -: 2] inside {2'd0, 2'd3});
endmodule

// File: tb/eaqf_top_tb_top.sv
`timescale 1ns/100ps
module eaqf_top_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, ir_en, dr_en, flt_valid;
    logic [63:0] req_ea, flt_ea;
    logic [1:0]  req_acc, flt_acc;
    logic [19:0] pid_reg;
    logic [11:0] lpid_reg;
    logic [31:0] flt_cause;
    logic        q_valid, q_real, exc_valid;
    logic [63:0] q_addr, far;
    logic [2:0]  q_perm, exc_code;
    logic [19:0] q_pid;
    logic [11:0] q_lpid;
    logic [31:0] err_code, fsr;

    int n_chk = 0;
    int n_bad = 0;
    logic [63:0] exp_far;
    logic [31:0] exp_fsr;

    always #2.5 clk = ~clk;

    eaqf_top dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ea(req_ea), .req_acc(req_acc),
        .ir_en(ir_en), .dr_en(dr_en), .pid_reg(pid_reg), .lpid_reg(lpid_reg),
        .flt_valid(flt_valid), .flt_ea(flt_ea), .flt_acc(flt_acc), .flt_cause(flt_cause),
        .q_valid(q_valid), .q_real(q_real), .q_addr(q_addr), .q_perm(q_perm),
        .q_pid(q_pid), .q_lpid(q_lpid), .exc_valid(exc_valid), .exc_code(exc_code),
        .err_code(err_code), .far(far), .fsr(fsr)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        req_valid = 0; flt_valid = 0;
    endtask

    task automatic step();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic send_req(input logic [63:0] ea, input logic [1:0] acc, input logic ir, input logic dr);
        req_valid = 1; req_ea = ea; req_acc = acc; ir_en = ir; dr_en = dr;
        step();
        idle();
    endtask

    task automatic send_flt(input logic [63:0] ea, input logic [1:0] acc, input logic [31:0] c);
        flt_valid = 1; flt_ea = ea; flt_acc = acc; flt_cause = c;
        step();
        idle();
    endtask

    task automatic t_reset();
        chk("R1 q_valid", 64'(q_valid), 0);
        chk("R1 exc_valid", 64'(exc_valid), 0);
        chk("R1 far", far, 0);
        chk("R1 fsr/err", {fsr, err_code}, 0);
    endtask

    task automatic t_bypass();
        send_req(64'hFFFF_0000_0000_1234, 2'd2, 1'b0, 1'b1);
        chk("R2 fetch real", {63'(q_valid), q_real}, 64'h3);
        chk("R2 fetch addr", q_addr, 64'h0FFF_0000_0000_1234);
        chk("R2 perm", 64'(q_perm), 7);
        chk("R2 no exc quad3", 64'(exc_valid), 0);
        send_req(64'h4ABC_0000_0000_0010, 2'd1, 1'b1, 1'b0);
        chk("R2 data real", {63'(q_valid), q_real}, 64'h3);
        chk("R2 data addr", q_addr, 64'h0ABC_0000_0000_0010);
        chk("R2 illegal quad ignored", 64'(exc_valid), 0);
        send_req(64'h0000_0000_0000_2000, 2'd2, 1'b1, 1'b0);
        chk("R2 fetch uses ir only", 64'(q_real), 0);
    endtask

    task automatic t_quad0();
        send_req(64'h0012_3456_789A_BCDE, 2'd0, 1'b1, 1'b1);
        chk("R3 valid/real", {63'(q_valid), q_real}, 64'h2);
        chk("R3 pid", 64'(q_pid), 64'h5A5A5);
        chk("R3 lpid", 64'(q_lpid), 64'h3C7);
        chk("R3 addr/perm", {q_addr[60:0], q_perm}, {61'h0012_3456_789A_BCDE, 3'b000});
    endtask

    task automatic t_quad3();
        send_req(64'hC000_0000_0000_8000, 2'd1, 1'b1, 1'b1);
        chk("R4 valid", 64'(q_valid), 1);
        chk("R4 pid zero", 64'(q_pid), 0);
        chk("R4 lpid", 64'(q_lpid), 64'h3C7);
    endtask

    task automatic t_seg();
        send_req(64'h4000_0000_0000_0100, 2'd2, 1'b1, 1'b1);
        chk("R5 q_valid low", 64'(q_valid), 0);
        chk("R5 exc", {63'(exc_valid), 1'b0} | 64'(exc_code), 64'h3);
        chk("R5 err", 64'(err_code), 0);
        chk("R5 far", far, exp_far);
        send_req(64'h8000_0000_0000_0040, 2'd0, 1'b0, 1'b1);
        exp_far = 64'h8000_0000_0000_0040;
        chk("R6 exc", 64'(exc_code), 2);
        chk("R6 far", far, exp_far);
        chk("R6 fsr", 64'(fsr), 64'(exp_fsr));
    endtask

    task automatic t_storage();
        send_flt(64'h0000_0000_DEAD_0000, 2'd2, 32'h4000_0000);
        chk("R7 exc", 64'(exc_code), 3);
        chk("R7 err", 64'(err_code), 64'h4000_0000);
        chk("R7 far/fsr", {far ^ exp_far}, 0);
        chk("R7 fsr", 64'(fsr), 64'(exp_fsr));
        send_flt(64'h0000_1111_2222_3330, 2'd0, 32'h0800_0000);
        exp_far = 64'h0000_1111_2222_3330; exp_fsr = 32'h0800_0000;
        chk("R8 exc", 64'(exc_code), 4);
        chk("R8 err", 64'(err_code), 0);
        chk("R8 fsr", 64'(fsr), 64'(exp_fsr));
        chk("R8 far", far, exp_far);
        send_flt(64'hC000_0000_0000_0008, 2'd1, 32'h0800_0000);
        exp_far = 64'hC000_0000_0000_0008; exp_fsr = 32'h0A00_0000;
        chk("R9 fsr store", 64'(fsr), 64'(exp_fsr));
        chk("R9 far", far, exp_far);
    endtask

    task automatic t_pulse();
        flt_valid = 1; flt_ea = 64'h10; flt_acc = 2'd0; flt_cause = 32'h1;
        step();
        flt_ea = 64'h20; flt_cause = 32'h2;
        step();
        idle();
        exp_far = 64'h20; exp_fsr = 32'h2;
        chk("R10 back-to-back far", far, exp_far);
        chk("R10 back-to-back valid", 64'(exc_valid), 1);
        step();
        chk("R10 pulse ends", 64'(exc_valid), 0);
        chk("R10 regs held", {far[31:0], fsr}, {exp_far[31:0], exp_fsr});
    endtask

    task automatic t_both();
        req_valid = 1; req_ea = 64'h8000_0000_0000_0777; req_acc = 2'd0; ir_en = 1; dr_en = 1;
        flt_valid = 1; flt_ea = 64'h0000_0000_0000_0999; flt_acc = 2'd0; flt_cause = 32'h0000_0040;
        step();
        idle();
        chk("R11 code", 64'(exc_code), 4);
        chk("R11 far", far, 64'h999);
        step();
        chk("R11 segment dropped", 64'(exc_valid), 0);
    endtask

    initial begin
        idle();
        req_ea = 0; req_acc = 0; ir_en = 1; dr_en = 1; flt_ea = 0; flt_acc = 0; flt_cause = 0;
        pid_reg = 20'h5A5A5; lpid_reg = 12'h3C7;
        exp_far = 0; exp_fsr = 0;
        rst = 1;
        repeat (3) @(negedge clk);
        t_reset();
        rst = 0;
        step();
        t_reset();
        t_bypass();
        t_quad0();
        t_quad3();
        t_seg();
        t_storage();
        t_pulse();
        t_both();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule